// File: doc/BRIEF.md
# ECC Memory Datapath

This block is the error-correction slice of a 64-bit memory controller. It sits between a CPU-side write and read port and a 72-bit memory port. On the memory side, the upper 64 bits carry data and the low 8 bits carry check bits. On writes it computes single-error-correct, double-error-detect check bits with an extended Hamming (72,64) code. On reads it recomputes the syndrome and repairs any single flipped bit. It flags single errors as correctable (CE) and double errors as uncorrectable (UE). The corrected word and its flags come back one cycle after the memory beat. The corrected word is never written back to memory.

A small register port holds two registers. The configuration register enables checking and enables machine-check reporting. The status register records the kind of error seen, plus the syndrome and burst beat of the first error since the last clear. Error checking is off after reset. While it is off, the check lane in memory is not kept up to date, so software must rewrite memory before it relies on correction. Read bursts are four beats long. The memory side marks the first beat of each burst, and the block numbers the beats that follow.

Top module: `mem_ecc_top`

## Requirements
- R1: After reset, both configuration bits are 0, the status register reads 0, `mcIrq` is low and `cpuRdValid` is low.
- R2: While ECC is disabled, every read beat returns its 64 data bits unchanged one cycle later. No CE or UE flag is raised, even when the stored word is corrupted.
- R3: Register address 0 is the configuration register. Bit 0 enables ECC generation and checking, and bit 1 enables machine-check reporting. Both bits read back, and a written value takes effect from the next cycle.
- R4: A CPU write appears on the memory port in the same cycle. `memWrEn` follows `cpuWrEn`, `memWrWord[71:8]` carries the write data and `memWrBe` carries the byte enables. Byte enable k covers the big-endian byte k, which is data bits [63-8k:56-8k]: enable 0 is the most significant byte, and enables 0 to 3 form the upper 32-bit word. `memChkWe` is high only when ECC is enabled and all eight enables are set.
- R5: With ECC enabled, a clean stored word reads back unchanged with no flag.
- R6: With ECC enabled, a word with one flipped bit, in the data or in the check lane, reads back corrected with CE set, one cycle after the beat.
- R7: With ECC enabled, a word with two flipped bits raises UE and not CE, and its data is returned uncorrected.
- R8: A location whose data was rewritten while ECC was disabled reports UE when it is read after ECC is enabled again.
- R9: Register address 1 is the status register. Bit 0 is a sticky CE flag and bit 1 is a sticky UE flag. Bits [15:8] hold the syndrome of the first error, and bit 15 (the overall-parity bit) is 1 for a CE and 0 for a UE. Bits [17:16] hold the burst beat of the first error. Later errors set the sticky flags but leave the syndrome and beat fields unchanged.
- R10: Writing 0xFFFF_FFFF to the status register clears it. Writing any other value has no effect.
- R11: `mcIrq` is high exactly when the status UE flag is set and machine-check reporting is enabled. It is held low while reporting is masked.
- R12: A beat with `memRdStart` high is beat 0, and the following valid beats are numbered 1, 2, 3 on `cpuRdBeat`. A UE in any beat of a burst is flagged on that beat.
- R13: CE and UE are never both asserted, and neither is asserted without `cpuRdValid`. This holds even for words with three or more bit errors, where the flag values are otherwise unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuWrData | input | 64 | CPU write data, big-endian byte lanes |
| cpuWrBe | input | 8 | CPU byte enables, enable 0 is the most significant byte |
| memWrEn | output | 1 | Memory write strobe |
| memWrWord | output | 72 | Data [71:8] and check bits [7:0] to memory |
| memWrBe | output | 8 | Data lane enables to memory |
| memChkWe | output | 1 | Check lane write enable |
| memRdValid | input | 1 | Read beat valid from memory |
| memRdStart | input | 1 | Marks the first beat of a burst |
| memRdWord | input | 72 | Read word from memory |
| cpuRdValid | output | 1 | Read data valid to the CPU |
| cpuRdData | output | 64 | Read data, corrected when ECC is enabled |
| cpuRdBeat | output | 2 | Beat index within the burst |
| cpuRdCe | output | 1 | Correctable error on this beat |
| cpuRdUe | output | 1 | Uncorrectable error on this beat |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects configuration, 1 selects status |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| mcIrq | output | 1 | Machine-check interrupt |

## Verification
The hardest case to reach from the ports is a stale check lane. It needs a location whose check bits were valid once and whose data then changed while checking was off. The bench gets there by writing a word with ECC enabled, disabling it, rewriting two data bits, and re-enabling it. The bench holds its own 72-bit memory model, fed from the block's write outputs, and flips chosen bits of the stored word on each read. This lets single, double and triple errors land on any beat of a four-beat burst. Status reads between bursts check that the first syndrome and beat survive later errors.

// File: rtl/mem_ecc_pkg.sv
package mem_ecc_pkg;
  localparam int DATA_W    = 64;
  localparam int HAM_W     = 7;
  localparam int CHK_W     = HAM_W + 1;
  localparam int WORD_W    = DATA_W + CHK_W;
  localparam int LANES     = DATA_W / 8;
  localparam int POS_MAX   = DATA_W + HAM_W;
  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = $clog2(BURST_LEN);
  localparam int REG_W     = 32;
  localparam int ST_SYN_LSB  = 8;
  localparam int ST_BEAT_LSB = 16;

  // control -> datapath strobes
  typedef struct packed {
    logic              genEn;
    logic              chkEn;
    logic [BEAT_W-1:0] beat;
  } ctl_strobe_t;

  // datapath -> control error event
  typedef struct packed {
    logic             err;
    logic             ce;
    logic             ue;
    logic [CHK_W-1:0] syn;
  } dp_event_t;

  // Hamming positions 1..POS_MAX; powers of two hold check bits, the rest hold data
  function automatic logic [HAM_W-1:0] hamParity(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] acc;
    int idx;
    acc = '0;
    idx = 0;
    for (int pos = 1; pos <= POS_MAX; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[idx]) acc = acc ^ pos[HAM_W-1:0];
        idx++;
      end
    end
    return acc;
  endfunction

  // top check bit makes the whole 72-bit word even parity
  function automatic logic [CHK_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] ham;
    ham = hamParity(d);
    return {^{d, ham}, ham};
  endfunction

  function automatic logic [DATA_W-1:0] eccCorrect(input logic [DATA_W-1:0] d,
                                                   input logic [HAM_W-1:0] s);
    logic [DATA_W-1:0] r;
    int idx;
    r = d;
    idx = 0;
    for (int pos = 1; pos <= POS_MAX; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (pos == int'(s)) r[idx] = ~r[idx];
        idx++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/mem_ecc_dp.sv
module mem_ecc_dp
  import mem_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [CHK_W-1:0]  wrCheck,
  input  logic              rdValidIn,
  input  logic [WORD_W-1:0] rdWordIn,
  output dp_event_t         evt,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [BEAT_W-1:0] rdBeat,
  output logic              rdCe,
  output logic              rdUe
);
  logic [DATA_W-1:0] rxData;
  logic [DATA_W-1:0] fixedData;
  logic [HAM_W-1:0]  synHam;
  logic              oddPar;
  logic              posOk;
  logic              isCe;
  logic              isUe;

  assign wrCheck = ctl.genEn ? eccEncode(wrData) : '0;

  always_comb begin
    rxData    = rdWordIn[WORD_W-1:CHK_W];
    synHam    = hamParity(rxData) ^ rdWordIn[HAM_W-1:0];
    oddPar    = ^rdWordIn;
    posOk     = (int'(synHam) <= POS_MAX);
    isCe      = oddPar && posOk;
    isUe      = (!oddPar && (synHam != '0)) || (oddPar && !posOk);
    fixedData = eccCorrect(rxData, synHam);
    evt.err   = rdValidIn && ctl.chkEn && (isCe || isUe);
    evt.ce    = isCe;
    evt.ue    = isUe;
    evt.syn   = {oddPar, synHam};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
      rdBeat  <= '0;
      rdCe    <= 1'b0;
      rdUe    <= 1'b0;
    end else begin
      rdValid <= rdValidIn;
      rdBeat  <= ctl.beat;
      rdData  <= (ctl.chkEn && isCe) ? fixedData : rxData;
      rdCe    <= rdValidIn && ctl.chkEn && isCe;
      rdUe    <= rdValidIn && ctl.chkEn && isUe;
    end
  end

  // R13
  flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdCe && rdUe));

  // R2
  flags_need_ecc_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.chkEn |=> (!rdCe && !rdUe));

  // R6
  ce_one_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValidIn && ctl.chkEn && isCe) |=> ($countones(rdData ^ $past(rxData)) <= 1));
endmodule

// File: rtl/mem_ecc_ctrl.sv
module mem_ecc_ctrl
  import mem_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWrEn,
  input  logic [LANES-1:0] cpuWrBe,
  input  logic             rdValidIn,
  input  logic             rdStartIn,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  dp_event_t        evt,
  output ctl_strobe_t      ctl,
  output logic             memChkWe,
  output logic [REG_W-1:0] regRdData,
  output logic             mcIrq
);
  logic              eccEn;
  logic              mcEn;
  logic [BEAT_W-1:0] beatCnt;
  logic [BEAT_W-1:0] curBeat;
  logic              stCe, stUe, stLogged;
  logic [CHK_W-1:0]  stSyn;
  logic [BEAT_W-1:0] stBeat;
  logic              nCe, nUe, nLog;
  logic [CHK_W-1:0]  nSyn;
  logic [BEAT_W-1:0] nBeat;
  logic              clr;
  logic              cfgWr;

  assign curBeat   = rdStartIn ? '0 : beatCnt;
  assign ctl.genEn = eccEn;
  assign ctl.chkEn = eccEn;
  assign ctl.beat  = curBeat;
  assign memChkWe  = cpuWrEn && eccEn && (&cpuWrBe);
  assign cfgWr     = regWrEn && !regAddr;
  assign clr       = regWrEn && regAddr && (regWrData == '1);
  assign mcIrq     = stUe && mcEn;

  always_comb begin
    nCe = stCe; nUe = stUe; nSyn = stSyn; nBeat = stBeat; nLog = stLogged;
    if (clr) begin
      nCe = 1'b0; nUe = 1'b0; nSyn = '0; nBeat = '0; nLog = 1'b0;
    end
    if (evt.err) begin
      nCe = nCe | evt.ce;
      nUe = nUe | evt.ue;
      if (!nLog) begin
        nSyn  = evt.syn;
        nBeat = curBeat;
        nLog  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eccEn <= 1'b0; mcEn <= 1'b0; beatCnt <= '0;
      stCe <= 1'b0; stUe <= 1'b0; stSyn <= '0; stBeat <= '0; stLogged <= 1'b0;
    end else begin
      if (cfgWr) begin
        eccEn <= regWrData[0];
        mcEn  <= regWrData[1];
      end
      if (rdValidIn) beatCnt <= curBeat + BEAT_W'(1);
      stCe <= nCe; stUe <= nUe; stSyn <= nSyn; stBeat <= nBeat; stLogged <= nLog;
    end
  end

  always_comb begin
    regRdData = '0;
    if (!regAddr) begin
      regRdData[0] = eccEn;
      regRdData[1] = mcEn;
    end else begin
      regRdData[0] = stCe;
      regRdData[1] = stUe;
      regRdData[ST_SYN_LSB +: CHK_W]   = stSyn;
      regRdData[ST_BEAT_LSB +: BEAT_W] = stBeat;
    end
  end

  // R11
  ue_raises_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evt.err && evt.ue && mcEn && !cfgWr) |=> mcIrq);

  // R9
  first_capture_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stLogged && !clr) |=> ($stable(stSyn) && $stable(stBeat)));

  // R10
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clr && !evt.err) |=> (!stCe && !stUe && stSyn == '0));

  // R12
  beat_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValidIn && rdStartIn) |=> (beatCnt == BEAT_W'(1)));
endmodule

// File: rtl/mem_ecc_top.sv
module mem_ecc_top
  import mem_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [LANES-1:0]  cpuWrBe,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrWord,
  output logic [LANES-1:0]  memWrBe,
  output logic              memChkWe,
  input  logic              memRdValid,
  input  logic              memRdStart,
  input  logic [WORD_W-1:0] memRdWord,
  output logic              cpuRdValid,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [BEAT_W-1:0] cpuRdBeat,
  output logic              cpuRdCe,
  output logic              cpuRdUe,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              mcIrq
);
  ctl_strobe_t      ctl;
  dp_event_t        evt;
  logic [CHK_W-1:0] wrCheck;

  assign memWrEn   = cpuWrEn;
  assign memWrBe   = cpuWrBe;
  assign memWrWord = {cpuWrData, wrCheck};

  mem_ecc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuWrBe(cpuWrBe),
    .rdValidIn(memRdValid), .rdStartIn(memRdStart),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .evt(evt), .ctl(ctl), .memChkWe(memChkWe), .regRdData(regRdData), .mcIrq(mcIrq)
  );

  mem_ecc_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(cpuWrData), .wrCheck(wrCheck),
    .rdValidIn(memRdValid), .rdWordIn(memRdWord), .evt(evt),
    .rdValid(cpuRdValid), .rdData(cpuRdData), .rdBeat(cpuRdBeat),
    .rdCe(cpuRdCe), .rdUe(cpuRdUe)
  );
endmodule

// File: tb/mem_ecc_top_tb.sv
module mem_ecc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NLOC = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [63:0] cpuWrData = '0;
  logic [7:0]  cpuWrBe = '0;
  logic        memWrEn;
  logic [71:0] memWrWord;
  logic [7:0]  memWrBe;
  logic        memChkWe;
  logic        memRdValid = 1'b0;
  logic        memRdStart = 1'b0;
  logic [71:0] memRdWord = '0;
  logic        cpuRdValid;
  logic [63:0] cpuRdData;
  logic [1:0]  cpuRdBeat;
  logic        cpuRdCe, cpuRdUe;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mcIrq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [71:0] mem [NLOC];
  logic [63:0] shadow [NLOC];
  int wrAddr = 0;

  typedef struct {
    logic [63:0] d;
    logic ce, ue;
    logic [1:0] beat;
    bit flagsKnown, dataKnown;
    string req;
  } exp_t;
  exp_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_ecc_top dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bench memory, fed from the write outputs
  always @(posedge clk) begin
    if (memWrEn) begin
      for (int k = 0; k < 8; k++)
        if (memWrBe[k]) mem[wrAddr][71-8*k -: 8] <= memWrWord[71-8*k -: 8];
      if (memChkWe) mem[wrAddr][7:0] <= memWrWord[7:0];
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (cpuRdValid) begin
        if (sbQ.size() == 0) begin
          chk(0, "R2", "unexpected read beat", 64'(cpuRdValid), 64'd0);
        end else begin
          exp_t e;
          e = sbQ.pop_front();
          chk(!(cpuRdCe && cpuRdUe), "R13", "CE and UE together",
              64'({cpuRdCe, cpuRdUe}), 64'd0);
          chk(cpuRdBeat == e.beat, e.req, "beat", 64'(cpuRdBeat), 64'(e.beat));
          if (e.dataKnown) chk(cpuRdData == e.d, e.req, "data", cpuRdData, e.d);
          if (e.flagsKnown)
            chk(cpuRdCe == e.ce && cpuRdUe == e.ue, e.req, "flags ce,ue",
                64'({cpuRdCe, cpuRdUe}), 64'({e.ce, e.ue}));
        end
      end else if (cpuRdCe || cpuRdUe) begin
        chk(0, "R13", "flag without valid", 64'({cpuRdCe, cpuRdUe}), 64'd0);
      end
    end
  end

  task automatic cpuWrite(input int a, input logic [63:0] d, input logic [7:0] be,
                          input logic expChkWe);
    @(negedge clk);
    wrAddr = a; cpuWrEn = 1'b1; cpuWrData = d; cpuWrBe = be;
    #1;
    chk(memWrEn && memWrWord[71:8] == d && memWrBe == be, "R4", "write pass-through",
        memWrWord[71:8], d);
    chk(memChkWe == expChkWe, "R4", "check lane enable", 64'(memChkWe), 64'(expChkWe));
    for (int k = 0; k < 8; k++)
      if (be[k]) shadow[a][63-8*k -: 8] = d[63-8*k -: 8];
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  // rawExp: expect stored data with flips applied, else the clean shadow copy
  task automatic readBeat(input int a, input logic [71:0] flip, input bit start,
                          input bit rawExp, input logic eCe, input logic eUe,
                          input bit flagsKnown, input bit dataKnown,
                          input logic [1:0] eBeat, input string req);
    exp_t e;
    logic [71:0] w;
    @(negedge clk);
    w = mem[a] ^ flip;
    e.d = rawExp ? w[71:8] : shadow[a];
    e.ce = eCe; e.ue = eUe; e.beat = eBeat;
    e.flagsKnown = flagsKnown; e.dataKnown = dataKnown; e.req = req;
    sbQ.push_back(e);
    memRdValid = 1'b1; memRdStart = start; memRdWord = w;
  endtask

  task automatic readEnd();
    @(negedge clk);
    memRdValid = 1'b0; memRdStart = 1'b0;
    @(negedge clk);
  endtask

  task automatic regWrite(input logic a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [71:0] bitAt(input int p);
    return 72'(1) << p;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0] firstSyn;
    for (int i = 0; i < NLOC; i++) begin
      mem[i] = '0;
      shadow[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 values during reset and right after release
    rstN = 1'b1;
    regRead(1'b0, r); chk(r == 32'd0, "R1", "config after reset", 64'(r), 64'd0);
    regRead(1'b1, r); chk(r == 32'd0, "R1", "status after reset", 64'(r), 64'd0);
    chk(!mcIrq && !cpuRdValid, "R1", "irq/valid after reset",
        64'({mcIrq, cpuRdValid}), 64'd0);

    // R2 and R4: ECC off, raw pass-through, big-endian lanes
    cpuWrite(0, 64'h0123_4567_89AB_CDEF, 8'hFF, 1'b0);
    readBeat(0, bitAt(8) | bitAt(40), 1, 1, 0, 0, 1, 1, 2'd0, "R2");
    readEnd();
    cpuWrite(1, 64'h1111_2222_3333_4444, 8'hFF, 1'b0);
    cpuWrite(1, 64'hAA00_0000_0000_0055, 8'b1000_0001, 1'b0); // lane 0 = bits 63:56, lane 7 = 7:0
    readBeat(1, '0, 1, 1, 0, 0, 1, 1, 2'd0, "R4");
    readEnd();
    chk(shadow[1] == 64'hAA11_2222_3333_4455, "R4", "lane merge model",
        mem[1][71:8], 64'hAA11_2222_3333_4455);

    // R3: configuration
    regWrite(1'b0, 32'h3);
    regRead(1'b0, r); chk(r == 32'h3, "R3", "config readback", 64'(r), 64'h3);

    for (int i = 3; i < 8; i++)
      cpuWrite(i, 64'hDEAD_BEEF_0000_0000 ^ (64'(i) * 64'h0101_0101_0101_0101), 8'hFF, 1'b1);
    cpuWrite(9, 64'h0, 8'h0F, 1'b0); // R4 partial write never updates check lane

    // R5 clean, R6 single data and check-bit errors
    readBeat(3, '0, 1, 0, 0, 0, 1, 1, 2'd0, "R5");
    readEnd();
    readBeat(4, bitAt(30), 1, 0, 1, 0, 1, 1, 2'd0, "R6");
    readEnd();
    regRead(1'b1, r);
    chk(r[1:0] == 2'b01 && r[15] && r[17:16] == 2'd0, "R9", "status after CE",
        64'(r), 64'h8001);
    firstSyn = r[15:8];
    readBeat(5, bitAt(2), 1, 0, 1, 0, 1, 1, 2'd0, "R6");
    readEnd();
    // R7 double error, data raw
    readBeat(6, bitAt(12) | bitAt(70), 1, 1, 0, 1, 1, 1, 2'd0, "R7");
    readEnd();
    regRead(1'b1, r);
    chk(r[1:0] == 2'b11 && r[15:8] == firstSyn, "R9", "first syndrome held",
        64'(r[15:0]), 64'({firstSyn, 8'h03}));
    chk(mcIrq == 1'b1, "R11", "irq on UE", 64'(mcIrq), 64'd1);
    regWrite(1'b1, 32'h0000_1234);
    regRead(1'b1, r);
    chk(r[1:0] == 2'b11, "R10", "non-ones write ignored", 64'(r[1:0]), 64'h3);
    regWrite(1'b1, 32'hFFFF_FFFF);
    regRead(1'b1, r);
    chk(r == 32'd0, "R10", "status cleared", 64'(r), 64'd0);
    chk(mcIrq == 1'b0, "R11", "irq low after clear", 64'(mcIrq), 64'd0);

    // R11 masked reporting
    regWrite(1'b0, 32'h1);
    readBeat(7, bitAt(20) | bitAt(21), 1, 1, 0, 1, 1, 1, 2'd0, "R11");
    readEnd();
    regRead(1'b1, r);
    chk(r[1] == 1'b1 && mcIrq == 1'b0, "R11", "masked irq",
        64'({r[1], mcIrq}), 64'h2);
    regWrite(1'b0, 32'h3);
    #1;
    chk(mcIrq == 1'b1, "R11", "irq on unmask", 64'(mcIrq), 64'd1);
    regWrite(1'b1, 32'hFFFF_FFFF);

    // R12 burst with UE on beat 2
    readBeat(3, '0, 1, 0, 0, 0, 1, 1, 2'd0, "R12");
    readBeat(4, '0, 0, 0, 0, 0, 1, 1, 2'd1, "R12");
    readBeat(5, bitAt(33) | bitAt(50), 0, 1, 0, 1, 1, 1, 2'd2, "R12");
    readBeat(6, '0, 0, 0, 0, 0, 1, 1, 2'd3, "R12");
    readEnd();
    regRead(1'b1, r);
    chk(r[1:0] == 2'b10 && r[17:16] == 2'd2 && !r[15] && r[15:8] != 0, "R9",
        "UE beat/syndrome", 64'(r), 64'h2_0002);
    regWrite(1'b1, 32'hFFFF_FFFF);
    // burst: CE beat 1, UE beat 3
    readBeat(3, '0, 1, 0, 0, 0, 1, 1, 2'd0, "R12");
    readBeat(4, bitAt(64), 0, 0, 1, 0, 1, 1, 2'd1, "R12");
    readBeat(5, '0, 0, 0, 0, 0, 1, 1, 2'd2, "R12");
    readBeat(6, bitAt(9) | bitAt(10), 0, 1, 0, 1, 1, 1, 2'd3, "R12");
    readEnd();
    regRead(1'b1, r);
    chk(r[1:0] == 2'b11 && r[17:16] == 2'd1 && r[15], "R12", "first error beat",
        64'(r), 64'h1_8003);
    regWrite(1'b1, 32'hFFFF_FFFF);

    // R13 triple error: flags unspecified, exclusivity checked by monitor
    readBeat(3, bitAt(8) | bitAt(9) | bitAt(11), 1, 0, 0, 0, 0, 0, 2'd0, "R13");
    readEnd();
    regWrite(1'b1, 32'hFFFF_FFFF);

    // R8 stale check lane after rewrite with ECC off
    cpuWrite(10, 64'hCAFE_F00D_1234_5678, 8'hFF, 1'b1);
    regWrite(1'b0, 32'h0);
    cpuWrite(10, 64'hCAFE_F00D_1234_5678 ^ 64'h0000_0100_0000_8000, 8'hFF, 1'b0);
    regWrite(1'b0, 32'h1);
    readBeat(10, '0, 1, 1, 0, 1, 1, 1, 2'd0, "R8");
    readEnd();
    regRead(1'b1, r);
    chk(r[1] == 1'b1, "R8", "stale UE in status", 64'(r[1]), 64'd1);

    chk(sbQ.size() == 0, "R12", "scoreboard drained", 64'(sbQ.size()), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule